// File: doc/BRIEF.md
# Configuration-Space Window Decoder

This block sits behind a device's configuration registers and decides whether an incoming transaction belongs to the device. It looks at three resources the configuration logic owns: one memory base address window of 4 KB, one I/O port window of 64 ports, and one expansion ROM window of 32 KB. Each transaction arrives with an address, a space type (memory or I/O) and a valid strobe. One clock later the block reports which window, if any, claimed it, along with the byte offset inside that window.

The command-register enables and the ROM enable bit each qualify their own windows. The memory BAR and the ROM share memory space and may overlap. When they do, the ROM wins, so no more than one hit output is ever high. Base bits that fall below a window's alignment are ignored. A base value of zero decodes like any other. The data path behind the hit, the ROM contents and configuration cycles are all handled elsewhere.

Top module: `bar_window_decode`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all three hit outputs and the offset read zero.
- R2: A memory-space request with the strobe high, memory enable set and address bits 31:12 equal to memory base bits 31:12 raises hit_mem in the next cycle. The offset is then address bits 11:0, zero-extended. This holds unless R6 applies.
- R3: An I/O-space request with the strobe high, I/O enable set and address bits 15:6 equal to I/O base bits 15:6 raises hit_io in the next cycle, with offset address bits 5:0. Address bits 31:16 play no part.
- R4: A memory-space request with the strobe high, memory enable set, ROM register bit 0 set and address bits 31:15 equal to ROM register bits 31:15 raises hit_rom in the next cycle, with offset address bits 14:0.
- R5: When memory enable is clear, there is no memory or ROM hit. When I/O enable is clear, there is no I/O hit. When ROM register bit 0 is clear, there is no ROM hit. All of this holds whatever the base values are.
- R6: If a memory request matches both the ROM and memory windows, only hit_rom rises.
- R7: At most one hit is high in any cycle. An I/O request never raises hit_mem or hit_rom, and a memory request never raises hit_io.
- R8: A cycle with the strobe low gives all hits low and an offset of zero in the following cycle. A cycle with no hit also gives an offset of zero.
- R9: A base of zero is decoded normally.
- R10: Memory base bits 11:0, ROM register bits 14:1 and I/O base bits 5:0 have no effect on decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_io_en | input | 1 | I/O space enable from the command register |
| cmd_mem_en | input | 1 | Memory space enable from the command register |
| mem_bar_base | input | 32 | Memory BAR value |
| io_bar_base | input | 16 | I/O BAR value |
| rom_reg | input | 32 | Expansion ROM register; bit 0 is the enable |
| req_valid | input | 1 | Transaction address strobe |
| req_is_io | input | 1 | 1 for an I/O transaction, 0 for a memory transaction |
| req_addr | input | 32 | Transaction address |
| hit_mem | output | 1 | Registered memory BAR hit |
| hit_io | output | 1 | Registered I/O BAR hit |
| hit_rom | output | 1 | Registered ROM hit |
| hit_offset | output | 15 | Registered offset inside the matched window |

## Verification
Two memory-space matches can fall in the same cycle: the memory BAR window and the ROM window. The bench places the 4 KB BAR inside the 32 KB ROM window and then sweeps every combination of command enables, ROM enable and space type across addresses inside both windows, inside only one, and outside both. For each case, the expected hit and offset come from shift-and-compare arithmetic in the bench, which requires exactly one hit with ROM priority.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_MEM  = 2'd1,
      WIN_IO   = 2'd2,
      WIN_ROM  = 2'd3
   } win_sel_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/bwd_window_match.sv
module bwd_window_match #(
   parameter int CMP_W = 20
) (
   input  logic             enable,
   input  logic [CMP_W-1:0] addr_hi,
   input  logic [CMP_W-1:0] base_hi,
   output logic             match
);
   initial begin
      if (CMP_W < 1) $error("bwd_window_match: CMP_W must be positive");
   end

   assign match = enable && (addr_hi == base_hi);
endmodule

// File: rtl/bwd_select.sv
module bwd_select
   import bwd_pkg::*;
#(
   parameter int MEM_LOG2 = 12,
   parameter int IO_LOG2  = 6,
   parameter int ROM_LOG2 = 15,
   parameter int OFS_W    = 15
) (
   input  logic             mem_match,
   input  logic             io_match,
   input  logic             rom_match,
   input  logic [OFS_W-1:0] addr_lo,
   output win_sel_e         sel,
   output logic [OFS_W-1:0] offset
);
   localparam logic [OFS_W-1:0] MEM_MASK = OFS_W'((64'd1 << MEM_LOG2) - 64'd1);
   localparam logic [OFS_W-1:0] IO_MASK  = OFS_W'((64'd1 << IO_LOG2) - 64'd1);
   localparam logic [OFS_W-1:0] ROM_MASK = OFS_W'((64'd1 << ROM_LOG2) - 64'd1);

   initial begin
      if (OFS_W < MEM_LOG2 || OFS_W < IO_LOG2 || OFS_W < ROM_LOG2)
         $error("bwd_select: OFS_W narrower than a window");
   end

   always_comb begin
      sel    = WIN_NONE;
      offset = '0;
      if (rom_match) begin
         sel    = WIN_ROM;
         offset = addr_lo & ROM_MASK;
      end else if (mem_match) begin
         sel    = WIN_MEM;
         offset = addr_lo & MEM_MASK;
      end else if (io_match) begin
         sel    = WIN_IO;
         offset = addr_lo & IO_MASK;
      end
   end
endmodule

// File: rtl/bwd_out_reg.sv
module bwd_out_reg
   import bwd_pkg::*;
#(
   parameter int OFS_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  win_sel_e         sel,
   input  logic [OFS_W-1:0] offset,
   output logic             hit_mem,
   output logic             hit_io,
   output logic             hit_rom,
   output logic [OFS_W-1:0] hit_offset
);
   always_ff @(posedge clk) begin
      if (!rst_n || !strobe) begin
         hit_mem    <= 1'b0;
         hit_io     <= 1'b0;
         hit_rom    <= 1'b0;
         hit_offset <= '0;
      end else begin
         hit_mem    <= (sel == WIN_MEM);
         hit_io     <= (sel == WIN_IO);
         hit_rom    <= (sel == WIN_ROM);
         hit_offset <= offset;
      end
   end
endmodule

// File: rtl/bar_window_decode.sv
module bar_window_decode
   import bwd_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int IO_ADDR_W   = 16,
   parameter int MEM_LOG2    = 12,
   parameter int IO_LOG2     = 6,
   parameter int ROM_LOG2    = 15,
   parameter bit ROM_PRESENT = 1'b1,
   parameter int OFS_W       = max3(MEM_LOG2, IO_LOG2, ROM_LOG2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_io_en,
   input  logic                 cmd_mem_en,
   input  logic [ADDR_W-1:0]    mem_bar_base,
   input  logic [IO_ADDR_W-1:0] io_bar_base,
   input  logic [ADDR_W-1:0]    rom_reg,
   input  logic                 req_valid,
   input  logic                 req_is_io,
   input  logic [ADDR_W-1:0]    req_addr,
   output logic                 hit_mem,
   output logic                 hit_io,
   output logic                 hit_rom,
   output logic [OFS_W-1:0]     hit_offset
);
   localparam int MEM_CMP_W = ADDR_W - MEM_LOG2;
   localparam int IO_CMP_W  = IO_ADDR_W - IO_LOG2;
   localparam int ROM_CMP_W = ADDR_W - ROM_LOG2;

   initial begin
      if (IO_ADDR_W > ADDR_W) $error("bar_window_decode: I/O width exceeds address width");
      if (MEM_LOG2 >= ADDR_W || ROM_LOG2 >= ADDR_W) $error("bar_window_decode: window too large");
      if (IO_LOG2 < 2 || IO_LOG2 >= IO_ADDR_W) $error("bar_window_decode: bad I/O window");
      if (ROM_LOG2 < 1) $error("bar_window_decode: ROM window must leave room for the enable bit");
      if (OFS_W > ADDR_W) $error("bar_window_decode: offset wider than address");
   end

   logic mem_m, io_m, rom_m;
   logic mem_space;
   win_sel_e sel;
   logic [OFS_W-1:0] sel_offset;

   assign mem_space = !req_is_io;

   bwd_window_match #(.CMP_W(MEM_CMP_W)) u_mem_match (
      .enable  (cmd_mem_en && mem_space),
      .addr_hi (req_addr[ADDR_W-1:MEM_LOG2]),
      .base_hi (mem_bar_base[ADDR_W-1:MEM_LOG2]),
      .match   (mem_m)
   );

   bwd_window_match #(.CMP_W(IO_CMP_W)) u_io_match (
      .enable  (cmd_io_en && req_is_io),
      .addr_hi (req_addr[IO_ADDR_W-1:IO_LOG2]),
      .base_hi (io_bar_base[IO_ADDR_W-1:IO_LOG2]),
      .match   (io_m)
   );

   generate
      if (ROM_PRESENT) begin : g_rom
         bwd_window_match #(.CMP_W(ROM_CMP_W)) u_rom_match (
            .enable  (cmd_mem_en && mem_space && rom_reg[0]),
            .addr_hi (req_addr[ADDR_W-1:ROM_LOG2]),
            .base_hi (rom_reg[ADDR_W-1:ROM_LOG2]),
            .match   (rom_m)
         );
      end else begin : g_no_rom
         assign rom_m = 1'b0;
      end
   endgenerate

   bwd_select #(
      .MEM_LOG2 (MEM_LOG2),
      .IO_LOG2  (IO_LOG2),
      .ROM_LOG2 (ROM_LOG2),
      .OFS_W    (OFS_W)
   ) u_select (
      .mem_match (mem_m),
      .io_match  (io_m),
      .rom_match (rom_m),
      .addr_lo   (req_addr[OFS_W-1:0]),
      .sel       (sel),
      .offset    (sel_offset)
   );

   bwd_out_reg #(.OFS_W(OFS_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (req_valid),
      .sel        (sel),
      .offset     (sel_offset),
      .hit_mem    (hit_mem),
      .hit_io     (hit_io),
      .hit_rom    (hit_rom),
      .hit_offset (hit_offset)
   );

   logic unused_bits;
   assign unused_bits = ^{mem_bar_base[MEM_LOG2-1:0], io_bar_base[IO_LOG2-1:0],
                          rom_reg[ROM_LOG2-1:0], req_addr};
endmodule

// File: rtl/bwd_checks.sv
module bwd_checks (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_io_en,
   input logic        cmd_mem_en,
   input logic [31:0] rom_reg,
   input logic        req_valid,
   input logic        req_is_io,
   input logic [31:0] req_addr,
   input logic [31:0] mem_bar_base,
   input logic        hit_mem,
   input logic        hit_io,
   input logic        hit_rom,
   input logic [14:0] hit_offset
);
   // R7: at most one window claims a transaction
   a_r7_onehot_hits: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_mem, hit_io, hit_rom}));

   // R7: an I/O request never claims a memory-space window
   a_r7_io_not_mem: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_is_io |=> !hit_mem && !hit_rom);

   // R8: strobe low clears everything next cycle
   a_r8_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !hit_mem && !hit_io && !hit_rom && hit_offset == 15'd0);

   // R5: memory enable off blocks both memory-space windows
   a_r5_mem_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_mem_en |=> !hit_mem && !hit_rom);

   // R5: I/O enable off blocks the port window
   a_r5_io_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_io_en |=> !hit_io);

   // R5: ROM enable bit off blocks the ROM window
   a_r5_rom_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_reg[0] |=> !hit_rom);

   // R6: ROM window claims over the memory BAR
   a_r6_rom_priority: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_is_io && cmd_mem_en && rom_reg[0] &&
      (req_addr[31:15] == rom_reg[31:15]) |=> hit_rom && !hit_mem);

   // R2: memory BAR claim outside the ROM window
   a_r2_mem_hit: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_is_io && cmd_mem_en && !rom_reg[0] &&
      (req_addr[31:12] == mem_bar_base[31:12]) |=> hit_mem && hit_offset == 15'($past(req_addr[11:0])));
endmodule

bind bar_window_decode bwd_checks u_bwd_checks (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_io_en    (cmd_io_en),
   .cmd_mem_en   (cmd_mem_en),
   .rom_reg      (rom_reg),
   .req_valid    (req_valid),
   .req_is_io    (req_is_io),
   .req_addr     (req_addr),
   .mem_bar_base (mem_bar_base),
   .hit_mem      (hit_mem),
   .hit_io       (hit_io),
   .hit_rom      (hit_rom),
   .hit_offset   (hit_offset)
);

// File: tb/bar_window_decode_bench.sv
module bar_window_decode_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_io_en = 1'b0, cmd_mem_en = 1'b0;
   logic [31:0] mem_bar_base = '0, rom_reg = '0, req_addr = '0;
   logic [15:0] io_bar_base = '0;
   logic        req_valid = 1'b0, req_is_io = 1'b0;
   logic        hit_mem, hit_io, hit_rom;
   logic [14:0] hit_offset;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bar_window_decode u_bar_window_decode (
      .clk(clk), .rst_n(rst_n), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
      .mem_bar_base(mem_bar_base), .io_bar_base(io_bar_base), .rom_reg(rom_reg),
      .req_valid(req_valid), .req_is_io(req_is_io), .req_addr(req_addr),
      .hit_mem(hit_mem), .hit_io(hit_io), .hit_rom(hit_rom), .hit_offset(hit_offset)
   );

   // expected {hit_mem, hit_io, hit_rom, offset} from window arithmetic
   function automatic logic [17:0] model(input logic v, input logic io, input logic ce_io,
                                         input logic ce_mem, input logic [31:0] a);
      logic [31:0] rb;
      if (!v) return '0;
      if (io) begin
         if (ce_io && ((a % 65536) / 64) == (32'(io_bar_base) / 64))
            return {3'b010, 15'(a % 64)};
         return '0;
      end
      rb = rom_reg;
      if (ce_mem && rb[0] && (a / 32768) == (rb / 32768))
         return {3'b001, 15'(a % 32768)};
      if (ce_mem && (a / 4096) == (mem_bar_base / 4096))
         return {3'b100, 15'(a % 4096)};
      return '0;
   endfunction

   task automatic check(input string tag, input logic [17:0] exp);
      logic [17:0] got;
      got = {hit_mem, hit_io, hit_rom, hit_offset};
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got mem/io/rom=%b off=%h expected mem/io/rom=%b off=%h",
                  tag, got[17:15], got[14:0], exp[17:15], exp[14:0]);
      end
   endtask

   // drive at a falling edge, sample at the next falling edge
   task automatic apply(input string tag, input logic v, input logic io,
                        input logic ce_io, input logic ce_mem, input logic [31:0] a);
      logic [17:0] exp;
      req_valid = v; req_is_io = io; cmd_io_en = ce_io; cmd_mem_en = ce_mem; req_addr = a;
      exp = model(v, io, ce_io, ce_mem, a);
      @(negedge clk);
      check(tag, exp);
   endtask

   function automatic string tag_of(input logic [17:0] e, input logic io);
      if (e[15]) return "R4/R6";
      if (e[17]) return "R2";
      if (e[16]) return "R3";
      return io ? "R5/R7(io)" : "R5/R7(mem)";
   endfunction

   function automatic logic [31:0] sweep_addr(input int i);
      case (i)
         0: return 32'h1234_0010;
         1: return 32'h1234_5ABC;
         2: return 32'h1234_6004;
         3: return 32'h1234_8000;
         4: return 32'hBEEF_C06A;
         5: return 32'h0000_C07F;
         6: return 32'h0000_C080;
         default: return 32'h1234_C03F;
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", '0);

      // R10: junk below every window's alignment
      mem_bar_base = 32'h1234_5FFF;
      rom_reg      = 32'h1234_7FFE;
      io_bar_base  = 16'hC07F;

      for (int ce = 0; ce < 4; ce++) begin
         for (int re = 0; re < 2; re++) begin
            rom_reg[0] = re[0];
            for (int sp = 0; sp < 2; sp++) begin
               for (int k = 0; k < 8; k++) begin
                  logic [31:0] a;
                  a = sweep_addr(k);
                  apply(tag_of(model(1'b1, sp[0], ce[0], ce[1], a), sp[0]),
                        1'b1, sp[0], ce[0], ce[1], a);
               end
            end
         end
      end

      // R6: overlap yields only the ROM hit
      rom_reg[0] = 1'b1;
      apply("R6", 1'b1, 1'b0, 1'b1, 1'b1, 32'h1234_5001);
      check("R6", {3'b001, 15'h5001});
      // R8: strobe low after a hit clears outputs
      apply("R8", 1'b0, 1'b0, 1'b1, 1'b1, 32'h1234_5001);
      check("R8", '0);
      // R7: I/O request on memory-window address
      apply("R7", 1'b1, 1'b1, 1'b1, 1'b1, 32'h1234_5001);
      // R3: upper bits ignored for I/O
      apply("R3", 1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFF_C041);
      check("R3", {3'b010, 15'h0001});
      // R10: low base bits do not widen the memory window
      rom_reg[0] = 1'b0;
      apply("R10", 1'b1, 1'b0, 1'b0, 1'b1, 32'h1234_4FFF);
      check("R10", '0);

      // R9: zero bases decode normally
      mem_bar_base = '0; io_bar_base = '0; rom_reg = 32'h0000_0000;
      apply("R9", 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_0FFF);
      check("R9", {3'b100, 15'h0FFF});
      apply("R9", 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_003F);
      check("R9", {3'b010, 15'h003F});
      rom_reg = 32'h0000_0001;
      apply("R9", 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_7FFF);
      check("R9", {3'b001, 15'h7FFF});
      // R4: ROM enable bit alone insufficient without memory enable (R5)
      apply("R5", 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_7FFF);
      check("R5", '0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule